// File: doc/BRIEF.md
# Bus Transfer Modifier with Link and Carry Flags

This block is the modify stage of a 16-bit register-transfer datapath. A value already chosen by a source selector enters on `src_data`, and the block may invert it. It then applies one of four modify steps: pass it unchanged, increment it, or rotate it by one place left or right through a one-bit link flag. The block registers the result for the destination side and updates its link and bus-carry flags in the same clock edge.

Two other command streams share the flags. A function-out command can clear, set or toggle the link, and it can raise a one-cycle halt request. A skip test combines an always-true term, the link and the carry under a request mask, and it can invert the outcome with a sense bit. The block does not decode sources or destinations and does not access memory.

Top module: `bus_xfer_mod`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `res_data` is 0 and `res_vld`, `link_q`, `carry_q`, `halt_req` and `sk_take` are all 0.
- R2: On the clock edge that samples `xfer_vld`=1, the block registers a result into `res_data` and pulses `res_vld` for one cycle. `xfer_op[1]`=1 inverts all 16 bits of `src_data` before the modify step, and `xfer_op[0]` is ignored.
- R3: Modify code `xfer_op[3:2]`=01 (increment) gives the operand plus one, modulo 2^16. It sets `carry_q` to the carry out of bit 15, so the flag is 1 exactly when the result wraps to 0 and is cleared otherwise.
- R4: Modify code 10 (rotate left) moves the old `link_q` into result bit 0 and operand bit 15 into `link_q`.
- R5: Modify code 11 (rotate right) moves the old `link_q` into result bit 15 and operand bit 0 into `link_q`.
- R6: Modify code 00 (pass), with or without inversion, leaves both flags unchanged. Rotates leave `carry_q` unchanged, and increment leaves `link_q` unchanged.
- R7: When `fo_vld`=1, `fo_cmd` acts on the link: 00 has no effect, 01 clears it, 10 sets it and 11 toggles it. If a transfer falls in the same cycle, the command acts on the link value that the transfer produced.
- R8: When `fo_vld`=1 and `fo_halt`=1, `halt_req` is 1 for exactly the next cycle. Otherwise it is 0.
- R9: When `sk_vld`=1, `sk_take` in the next cycle equals (`sk_req[3]` or (`sk_req[2]` and link) or (`sk_req[1]` and carry)) XOR `sk_req[0]`. The link and carry used are the values held before that cycle's updates. When `sk_vld`=0, `sk_take` is 0 in the next cycle.
- R10: With no transfer and no function-out command, `res_data`, `link_q` and `carry_q` hold their values, and `res_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_vld | input | 1 | Transfer strobe |
| xfer_op | input | 4 | [3:2] modify code, [1] invert, [0] unused |
| src_data | input | 16 | Selected source value |
| fo_vld | input | 1 | Function-out command strobe |
| fo_cmd | input | 2 | Link command: 00 none, 01 clear, 10 set, 11 toggle |
| fo_halt | input | 1 | Halt request bit of the function-out command |
| sk_vld | input | 1 | Skip test strobe |
| sk_req | input | 4 | [3] always, [2] link, [1] carry, [0] reverse sense |
| res_data | output | 16 | Registered transfer result |
| res_vld | output | 1 | One-cycle pulse marking a new result |
| link_q | output | 1 | Link flag |
| carry_q | output | 1 | Bus-carry flag |
| halt_req | output | 1 | One-cycle halt request |
| sk_take | output | 1 | Registered skip decision |

## Verification
A transfer and a function-out command can both change the link in the same cycle. The bench provokes this by combining a rotate with a toggle and a rotate with a set. It expects the command to act on the link that the rotate produced, and it checks both the rotated data and the final link. A skip test can also fall in the same cycle as a rotate that flips the link. There the bench expects the skip to see the link value from before the rotate.

// File: rtl/bxm_pkg.sv
package bxm_pkg;
  typedef enum logic [1:0] {
    MOD_PASS = 2'b00,
    MOD_INC  = 2'b01,
    MOD_ROL  = 2'b10,
    MOD_ROR  = 2'b11
  } mod_e;

  typedef enum logic [1:0] {
    LK_KEEP = 2'b00,
    LK_CLR  = 2'b01,
    LK_SET  = 2'b10,
    LK_TGL  = 2'b11
  } lk_e;
endpackage

// File: rtl/bxm_modify.sv
module bxm_modify
  import bxm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] din,
  input  logic          inv,
  input  mod_e          mode,
  input  logic          link_in,
  output logic [DW-1:0] dout,
  output logic          link_out,
  output logic          link_upd,
  output logic          carry_out,
  output logic          carry_upd
);
  localparam int RW = DW + 1;

  logic [DW-1:0] opnd;
  logic [RW-1:0] sum;

  assign opnd = inv ? ~din : din;
  assign sum  = {1'b0, opnd} + {{DW{1'b0}}, 1'b1};

  always_comb begin
    dout      = opnd;
    link_out  = link_in;
    link_upd  = 1'b0;
    carry_out = 1'b0;
    carry_upd = 1'b0;
    unique case (mode)
      MOD_PASS: ;
      MOD_INC: begin
        dout      = sum[DW-1:0];
        carry_out = sum[DW];
        carry_upd = 1'b1;
      end
      MOD_ROL: begin
        dout     = {opnd[DW-2:0], link_in};
        link_out = opnd[DW-1];
        link_upd = 1'b1;
      end
      MOD_ROR: begin
        dout     = {link_in, opnd[DW-1:1]};
        link_out = opnd[0];
        link_upd = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bxm_flags.sv
module bxm_flags
  import bxm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic xfer_en,
  input  logic link_upd,
  input  logic link_nxt,
  input  logic carry_upd,
  input  logic carry_nxt,
  input  logic cmd_en,
  input  lk_e  cmd,
  output logic link_r,
  output logic carry_r
);
  logic link_mid;
  logic link_fin;

  always_comb begin
    link_mid = (xfer_en && link_upd) ? link_nxt : link_r;
    link_fin = link_mid;
    if (cmd_en) begin
      unique case (cmd)
        LK_KEEP: link_fin = link_mid;
        LK_CLR:  link_fin = 1'b0;
        LK_SET:  link_fin = 1'b1;
        LK_TGL:  link_fin = ~link_mid;
        default: link_fin = link_mid;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      link_r  <= 1'b0;
      carry_r <= 1'b0;
    end else begin
      link_r <= link_fin;
      if (xfer_en && carry_upd) carry_r <= carry_nxt;
    end
  end
endmodule

// File: rtl/bxm_skip.sv
module bxm_skip (
  input  logic       clk,
  input  logic       rst,
  input  logic       test_en,
  input  logic [3:0] req,
  input  logic       link,
  input  logic       carry,
  output logic       take
);
  logic cond;

  assign cond = req[3] | (req[2] & link) | (req[1] & carry);

  always_ff @(posedge clk) begin
    if (rst) take <= 1'b0;
    else     take <= test_en & (cond ^ req[0]);
  end
endmodule

// File: rtl/bus_xfer_mod.sv
module bus_xfer_mod
  import bxm_pkg::*;
#(
  parameter int DW = 16,
  parameter int OPW = 4,
  parameter int SKW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           xfer_vld,
  input  logic [OPW-1:0] xfer_op,
  input  logic [DW-1:0]  src_data,
  input  logic           fo_vld,
  input  logic [1:0]     fo_cmd,
  input  logic           fo_halt,
  input  logic           sk_vld,
  input  logic [SKW-1:0] sk_req,
  output logic [DW-1:0]  res_data,
  output logic           res_vld,
  output logic           link_q,
  output logic           carry_q,
  output logic           halt_req,
  output logic           sk_take
);
  localparam int INV_BIT = 1;
  localparam int MOD_LSB = 2;

  mod_e          mode;
  logic [DW-1:0] mod_out;
  logic          lk_nxt, lk_upd, cy_nxt, cy_upd;

  assign mode = mod_e'(xfer_op[MOD_LSB +: 2]);

  bxm_modify #(.DW(DW)) u_mod (
    .din       (src_data),
    .inv       (xfer_op[INV_BIT]),
    .mode      (mode),
    .link_in   (link_q),
    .dout      (mod_out),
    .link_out  (lk_nxt),
    .link_upd  (lk_upd),
    .carry_out (cy_nxt),
    .carry_upd (cy_upd)
  );

  bxm_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .xfer_en   (xfer_vld),
    .link_upd  (lk_upd),
    .link_nxt  (lk_nxt),
    .carry_upd (cy_upd),
    .carry_nxt (cy_nxt),
    .cmd_en    (fo_vld),
    .cmd       (lk_e'(fo_cmd)),
    .link_r    (link_q),
    .carry_r   (carry_q)
  );

  bxm_skip u_skip (
    .clk     (clk),
    .rst     (rst),
    .test_en (sk_vld),
    .req     (sk_req[3:0]),
    .link    (link_q),
    .carry   (carry_q),
    .take    (sk_take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data <= '0;
      res_vld  <= 1'b0;
      halt_req <= 1'b0;
    end else begin
      res_vld  <= xfer_vld;
      halt_req <= fo_vld & fo_halt;
      if (xfer_vld) res_data <= mod_out;
    end
  end
endmodule

// File: rtl/bxm_chk.sv
module bxm_chk #(
  parameter int DW = 16,
  parameter int OPW = 4,
  parameter int SKW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           xfer_vld,
  input logic [OPW-1:0] xfer_op,
  input logic [DW-1:0]  src_data,
  input logic           fo_vld,
  input logic [1:0]     fo_cmd,
  input logic           fo_halt,
  input logic           sk_vld,
  input logic [SKW-1:0] sk_req,
  input logic [DW-1:0]  res_data,
  input logic           res_vld,
  input logic           link_q,
  input logic           carry_q,
  input logic           halt_req,
  input logic           sk_take
);
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (rst)
    xfer_vld |=> res_vld); // R2
  AST_NO_RES_PULSE: assert property (@(posedge clk) disable iff (rst)
    !xfer_vld |=> (!res_vld && $stable(res_data))); // R10
  AST_INC_CARRY: assert property (@(posedge clk) disable iff (rst)
    (xfer_vld && xfer_op[3:2] == 2'b01) |=> (carry_q == (res_data == '0))); // R3
  AST_ROL_FILL: assert property (@(posedge clk) disable iff (rst)
    (xfer_vld && xfer_op[3:2] == 2'b10) |=> (res_data[0] == $past(link_q))); // R4
  AST_ROR_FILL: assert property (@(posedge clk) disable iff (rst)
    (xfer_vld && xfer_op[3:2] == 2'b11) |=> (res_data[DW-1] == $past(link_q))); // R5
  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(xfer_vld && xfer_op[3:2] == 2'b01) |=> $stable(carry_q)); // R6
  AST_LINK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!fo_vld && !(xfer_vld && xfer_op[3])) |=> $stable(link_q)); // R6
  AST_LINK_SET: assert property (@(posedge clk) disable iff (rst)
    (fo_vld && fo_cmd == 2'b10) |=> link_q); // R7
  AST_HALT_PULSE: assert property (@(posedge clk) disable iff (rst)
    (fo_vld && fo_halt) |=> halt_req); // R8
  AST_SKIP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sk_vld |=> !sk_take); // R9
  AST_SKIP_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    (sk_vld && sk_req[3]) |=> (sk_take == !$past(sk_req[0]))); // R9
endmodule

bind bus_xfer_mod bxm_chk #(.DW(DW), .OPW(OPW), .SKW(SKW)) u_chk (.*);

// File: tb/bus_xfer_mod_tb.sv
module bus_xfer_mod_tb_top;
  localparam int DW = 16;
  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          xfer_vld = 1'b0;
  logic [3:0]    xfer_op = '0;
  logic [DW-1:0] src_data = '0;
  logic          fo_vld = 1'b0;
  logic [1:0]    fo_cmd = '0;
  logic          fo_halt = 1'b0;
  logic          sk_vld = 1'b0;
  logic [3:0]    sk_req = '0;
  logic [DW-1:0] res_data;
  logic          res_vld, link_q, carry_q, halt_req, sk_take;

  int n_chk = 0;
  int n_bad = 0;
  logic m_link = 1'b0;
  logic m_carry = 1'b0;

  always #5 clk = ~clk;

  bus_xfer_mod dut_i (.*);

  // {op, src}
  localparam logic [19:0] VEC [NV] = '{
    {4'h0, 16'h1234}, {4'h2, 16'h1234}, {4'h4, 16'hFFFF}, {4'h4, 16'h0001},
    {4'h6, 16'h0000}, {4'h5, 16'h7FFF}, {4'h8, 16'h8001}, {4'h8, 16'h0000},
    {4'hC, 16'h0001}, {4'hC, 16'h0000}, {4'hA, 16'h7FFF}, {4'hE, 16'hFFFE},
    {4'h1, 16'hA5A5}, {4'h3, 16'h00FF}, {4'hD, 16'h8000}, {4'h9, 16'h4000}
  };

  function automatic logic [17:0] model(input logic [3:0] op, input logic [15:0] s,
                                        input logic l, input logic c);
    logic [15:0] v;
    logic [16:0] t;
    v = op[1] ? ~s : s;
    case (op[3:2])
      2'b01: begin t = {1'b0, v} + 17'd1; return {t[15:0], l, t[16]}; end
      2'b10: return {v[14:0], l, v[15], c};
      2'b11: return {l, v[15:1], v[0], c};
      default: return {v, l, c};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic xv, input logic [3:0] op, input logic [15:0] s,
                      input logic fv, input logic [1:0] fc, input logic fh,
                      input logic sv, input logic [3:0] sr);
    xfer_vld = xv; xfer_op = op; src_data = s;
    fo_vld = fv; fo_cmd = fc; fo_halt = fh; sk_vld = sv; sk_req = sr;
    @(posedge clk); #1;
    xfer_vld = 0; fo_vld = 0; fo_halt = 0; sk_vld = 0;
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [17:0] e;
    logic [15:0] last;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check("R1 reset", {res_data, res_vld, link_q, carry_q, halt_req, sk_take}, '0);

    // R2 R3 R4 R5 R6: vector table
    for (int i = 0; i < NV; i++) begin
      e = model(VEC[i][19:16], VEC[i][15:0], m_link, m_carry);
      step(1, VEC[i][19:16], VEC[i][15:0], 0, 2'b00, 0, 0, 4'h0);
      m_link = e[1]; m_carry = e[0];
      check("R2/R3/R4/R5/R6 vector", {res_data, res_vld, link_q, carry_q},
            {e[17:2], 1'b1, e[1], e[0]});
    end

    // R10: idle cycle holds everything
    last = res_data;
    step(0, 4'h4, 16'hFFFF, 0, 2'b00, 0, 0, 4'h0);
    check("R10 idle hold", {res_data, res_vld, link_q, carry_q}, {last, 1'b0, m_link, m_carry});

    // R7: function-out link commands
    step(0, 4'h0, 16'h0, 1, 2'b10, 0, 0, 4'h0);
    check("R7 set", link_q, 1);
    step(0, 4'h0, 16'h0, 1, 2'b00, 0, 0, 4'h0);
    check("R7 none", link_q, 1);
    step(0, 4'h0, 16'h0, 1, 2'b11, 0, 0, 4'h0);
    check("R7 toggle", link_q, 0);
    step(0, 4'h0, 16'h0, 1, 2'b11, 0, 0, 4'h0);
    step(0, 4'h0, 16'h0, 1, 2'b01, 0, 0, 4'h0);
    check("R7 clear", link_q, 0);

    // R7: same-cycle rotate + toggle: rotate makes link 1, toggle gives 0
    step(1, 4'h8, 16'h8000, 1, 2'b11, 0, 0, 4'h0);
    check("R7 rol+toggle data", res_data, 16'h0000);
    check("R7 rol+toggle link", link_q, 0);
    // rotate right of 0 with link 0 -> link 0, then set -> 1
    step(1, 4'hC, 16'h0000, 1, 2'b10, 0, 0, 4'h0);
    check("R7 ror+set", {res_data, link_q}, {16'h0000, 1'b1});

    // R8: halt pulse
    step(0, 4'h0, 16'h0, 1, 2'b00, 1, 0, 4'h0);
    check("R8 halt high", halt_req, 1);
    step(0, 4'h0, 16'h0, 0, 2'b00, 0, 0, 4'h0);
    check("R8 halt one cycle", halt_req, 0);
    check("R8 halt keeps link", link_q, 1);

    // R9: skip tests; link=1, carry from increment below
    step(1, 4'h4, 16'hFFFF, 0, 2'b00, 0, 0, 4'h0);   // carry=1, link stays 1
    step(0, 4'h0, 16'h0, 0, 2'b00, 0, 1, 4'b1000);
    check("R9 always", sk_take, 1);
    step(0, 4'h0, 16'h0, 0, 2'b00, 0, 1, 4'b1001);
    check("R9 always reversed", sk_take, 0);
    step(0, 4'h0, 16'h0, 0, 2'b00, 0, 1, 4'b0000);
    check("R9 none", sk_take, 0);
    step(0, 4'h0, 16'h0, 0, 2'b00, 0, 1, 4'b0001);
    check("R9 none reversed", sk_take, 1);
    step(0, 4'h0, 16'h0, 0, 2'b00, 0, 1, 4'b0100);
    check("R9 link", sk_take, 1);
    step(0, 4'h0, 16'h0, 0, 2'b00, 0, 1, 4'b0010);
    check("R9 carry", sk_take, 1);
    step(1, 4'h4, 16'h0001, 0, 2'b00, 0, 0, 4'h0);   // carry=0
    step(0, 4'h0, 16'h0, 0, 2'b00, 0, 1, 4'b0010);
    check("R9 carry clear", sk_take, 0);
    // same cycle: rotate drops link to 0; skip must see old link 1
    step(1, 4'h8, 16'h0000, 0, 2'b00, 0, 1, 4'b0100);
    check("R9 old link seen", sk_take, 1);
    check("R4 link after rol", link_q, 0);
    step(0, 4'h0, 16'h0, 0, 2'b00, 0, 1, 4'b0100);
    check("R9 new link", sk_take, 0);
    step(0, 4'h0, 16'h0, 0, 2'b00, 0, 0, 4'b1000);
    check("R9 idle low", sk_take, 0);

    // R1: reset mid-run
    rst = 1;
    @(posedge clk); #1 rst = 0;
    check("R1 re-reset", {res_data, res_vld, link_q, carry_q, halt_req, sk_take}, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule